// File: doc/BRIEF.md
# Decimator Output Timing Controller

This block produces the output-rate timing for the decimation filter of an oversampled converter. From a master clock it derives a one-cycle data-ready strobe once per output period. The output period is twice the oversampling ratio, counted in master clocks, and the ratio is picked by a 3-bit select. The block also produces a free-running chop-phase tick and a busy flag. No filter arithmetic is done here. The block only decides when a settled output word exists.

A synchronize request restarts the filter. From that point the block withholds data-ready for a fixed number of output periods. It then adds an overhead, chosen by the speed-mode input, and an extra delay when the input buffers are enabled. The first strobe after a restart therefore already marks fully settled data, and downstream logic never needs to discard words. The ratio select, speed mode and buffer enable are taken only at the synchronize request. All later changes to them wait for the next restart.

Top module: `decim_rate_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `data_ready` stays 0 and `busy` stays 1 until a `sync_req` is sampled.
- R2: The select code k on `osr_sel` (0 to 7) sets the oversampling ratio 32·2^k, which is 32, 64, 128, 256, 512, 1024, 2048 or 4096. The output period P is 2·32·2^k master clocks.
- R3: If `sync_req` is sampled at clock edge E, then `data_ready` is first high in the cycle after edge E+L, where L = SETTLE_PERIODS·P + overhead + buffer delay. SETTLE_PERIODS defaults to 68. Before that cycle it is low.
- R4: After the first strobe, `data_ready` is high for exactly one cycle every P clocks until the next `sync_req` or reset.
- R5: `busy` is high from the cycle after a sampled `sync_req` up to the cycle before the first strobe. It is low from the first strobe onward.
- R6: A `sync_req` sampled during settling restarts the whole latency L, computed from the inputs present at that new request.
- R7: Changes to `osr_sel`, `low_speed` or `buf_en` after a `sync_req` do not affect the latency or the period until the next `sync_req`.
- R8: When `buf_en` is 1 at the `sync_req`, the latency grows by BUF_DELAY clocks (default 8).
- R9: The overhead is OVH_HS when `low_speed` is 0 at the `sync_req`, and OVH_LS when it is 1. Both default to 16.
- R10: `chop_tick` is high for one cycle every 64 master clocks. Counting from the last clock edge that sampled `rst` high, it is high in the cycle after edges 63, 127, 191 and so on.
- R11: A `sync_req` sampled while strobes are running stops them. The block re-enters settling with `busy` high.
- R12: A reset sampled while running clears `data_ready` and sets `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Filter restart request, sampled at the rising edge |
| osr_sel | input | 3 | Oversampling-ratio select code |
| low_speed | input | 1 | 1 selects the low-speed overhead |
| buf_en | input | 1 | Input buffers enabled; adds the buffer delay |
| data_ready | output | 1 | One-cycle strobe for a settled output word |
| chop_tick | output | 1 | One-cycle chop-phase tick every 64 clocks |
| busy | output | 1 | High from reset or restart until the first settled strobe |

## Verification
The first strobe is due L rising edges after the edge that samples the restart request. Repeats follow every P edges after that, and `busy` falls in the same cycle as the first strobe. Reset acts one edge after it is sampled, and `chop_tick` follows a bench-side edge count since reset. The bench counts rising edges from the sampling edge of each stimulus and compares outputs at the following falling edge. It computes the expected cycle from the formula in R3, so a strobe one cycle early or late is reported at that cycle. A second instance with a single settle period and a distinct low-speed overhead reaches all eight ratio codes within the run.

// File: rtl/decim_rate_pkg.sv
package decim_rate_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_RUN    = 2'd2
   } rate_state_e;

   // Longest output period for a given base ratio and select width.
   function automatic int unsigned longest_period(input int unsigned base_osr,
                                                  input int unsigned sel_w);
      return (2 * base_osr) << ((1 << sel_w) - 1);
   endfunction

   function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/decim_rate_cfg.sv
module decim_rate_cfg #(
   parameter int unsigned BASE_OSR       = 32,
   parameter int unsigned OSR_SEL_W      = 3,
   parameter int unsigned SETTLE_PERIODS = 68,
   parameter int unsigned OVH_HS         = 16,
   parameter int unsigned OVH_LS         = 16,
   parameter int unsigned BUF_DELAY      = 8,
   parameter int unsigned PER_W          = 14,
   parameter int unsigned CNT_W          = 20
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sync_req,
   input  logic [OSR_SEL_W-1:0] osr_sel,
   input  logic                 low_speed,
   input  logic                 buf_en,
   output logic [CNT_W-1:0]     load_latency,
   output logic [PER_W-1:0]     period_q
);

   logic [PER_W-1:0] per_live;
   logic [CNT_W-1:0] settle_live;
   logic [CNT_W-1:0] ovh_live;
   logic [CNT_W-1:0] bufd_live;

   // Period from the live select; only used at a restart.
   always_comb begin
      per_live    = PER_W'(2 * BASE_OSR) << osr_sel;
      settle_live = CNT_W'(per_live) * CNT_W'(SETTLE_PERIODS);
      ovh_live    = low_speed ? CNT_W'(OVH_LS) : CNT_W'(OVH_HS);
      bufd_live   = buf_en ? CNT_W'(BUF_DELAY) : '0;
      load_latency = settle_live + ovh_live + bufd_live;
   end

   // Period held for the running phase; changes only at a restart.
   always_ff @(posedge clk) begin
      if (rst) begin
         period_q <= PER_W'(2 * BASE_OSR);
      end else if (sync_req) begin
         period_q <= per_live;
      end
   end

endmodule

// File: rtl/decim_rate_strobe.sv
module decim_rate_strobe
   import decim_rate_pkg::*;
#(
   parameter int unsigned PER_W = 14,
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_req,
   input  logic [CNT_W-1:0] load_latency,
   input  logic [PER_W-1:0] period_q,
   output logic             data_ready,
   output logic             busy
);

   rate_state_e      state;
   logic [CNT_W-1:0] remain;
   logic             dr_q;
   logic             expire;

   assign expire = (remain == CNT_W'(1));

   // One down-counter serves both the settle hold-off and the period.
   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         remain <= '0;
         dr_q   <= 1'b0;
      end else if (sync_req) begin
         state  <= ST_SETTLE;
         remain <= load_latency;
         dr_q   <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               dr_q <= 1'b0;
            end
            default: begin
               if (expire) begin
                  dr_q   <= 1'b1;
                  state  <= ST_RUN;
                  remain <= CNT_W'(period_q);
               end else begin
                  dr_q   <= 1'b0;
                  remain <= remain - CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign data_ready = dr_q;
   assign busy       = (state != ST_RUN);

endmodule

// File: rtl/decim_chop_div.sv
module decim_chop_div #(
   parameter int unsigned CHOP_DIV = 64
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   localparam int unsigned CW = (CHOP_DIV > 2) ? $clog2(CHOP_DIV) : 1;
   localparam bit IS_POW2 = ((CHOP_DIV & (CHOP_DIV - 1)) == 0);

   logic [CW-1:0] phase;

   generate
      if (IS_POW2) begin : g_wrap
         // Natural wrap of the counter marks the tick.
         always_ff @(posedge clk) begin
            if (rst) phase <= '0;
            else     phase <= phase + CW'(1);
         end
         assign tick = &phase;
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)                             phase <= '0;
            else if (phase == CW'(CHOP_DIV - 1)) phase <= '0;
            else                                 phase <= phase + CW'(1);
         end
         assign tick = (phase == CW'(CHOP_DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/decim_rate_ctrl.sv
module decim_rate_ctrl
   import decim_rate_pkg::*;
#(
   parameter int unsigned BASE_OSR       = 32,
   parameter int unsigned OSR_SEL_W      = 3,
   parameter int unsigned SETTLE_PERIODS = 68,
   parameter int unsigned OVH_HS         = 16,
   parameter int unsigned OVH_LS         = 16,
   parameter int unsigned BUF_DELAY      = 8,
   parameter int unsigned MOD_CLK_DIV    = 2,
   parameter int unsigned CHOP_RATIO     = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sync_req,
   input  logic [OSR_SEL_W-1:0] osr_sel,
   input  logic                 low_speed,
   input  logic                 buf_en,
   output logic                 data_ready,
   output logic                 chop_tick,
   output logic                 busy
);

   localparam int unsigned MAX_PERIOD = longest_period(BASE_OSR, OSR_SEL_W);
   localparam int unsigned PER_W      = $clog2(MAX_PERIOD + 1);
   localparam int unsigned MAX_LAT    = SETTLE_PERIODS * MAX_PERIOD
                                        + larger_of(OVH_HS, OVH_LS) + BUF_DELAY;
   localparam int unsigned CNT_W      = $clog2(MAX_LAT + 1);
   localparam int unsigned CHOP_DIV   = MOD_CLK_DIV * CHOP_RATIO;

   // Elaboration-time parameter checks.
   generate
      if (BASE_OSR < 1) begin : g_bad_base
         $error("decim_rate_ctrl: BASE_OSR must be at least 1");
      end
      if (OSR_SEL_W < 1 || OSR_SEL_W > 4) begin : g_bad_selw
         $error("decim_rate_ctrl: OSR_SEL_W must lie in 1..4");
      end
      if (SETTLE_PERIODS < 1) begin : g_bad_settle
         $error("decim_rate_ctrl: SETTLE_PERIODS must be at least 1");
      end
      if (CHOP_DIV < 2) begin : g_bad_chop
         $error("decim_rate_ctrl: chop divide must be at least 2");
      end
      if (CNT_W > 31) begin : g_bad_width
         $error("decim_rate_ctrl: latency counter too wide");
      end
   endgenerate

   logic [CNT_W-1:0] load_latency;
   logic [PER_W-1:0] period_q;

   decim_rate_cfg #(
      .BASE_OSR       (BASE_OSR),
      .OSR_SEL_W      (OSR_SEL_W),
      .SETTLE_PERIODS (SETTLE_PERIODS),
      .OVH_HS         (OVH_HS),
      .OVH_LS         (OVH_LS),
      .BUF_DELAY      (BUF_DELAY),
      .PER_W          (PER_W),
      .CNT_W          (CNT_W)
   ) u_cfg (
      .clk          (clk),
      .rst          (rst),
      .sync_req     (sync_req),
      .osr_sel      (osr_sel),
      .low_speed    (low_speed),
      .buf_en       (buf_en),
      .load_latency (load_latency),
      .period_q     (period_q)
   );

   decim_rate_strobe #(
      .PER_W (PER_W),
      .CNT_W (CNT_W)
   ) u_strobe (
      .clk          (clk),
      .rst          (rst),
      .sync_req     (sync_req),
      .load_latency (load_latency),
      .period_q     (period_q),
      .data_ready   (data_ready),
      .busy         (busy)
   );

   decim_chop_div #(
      .CHOP_DIV (CHOP_DIV)
   ) u_chop (
      .clk  (clk),
      .rst  (rst),
      .tick (chop_tick)
   );

endmodule

// File: rtl/decim_rate_ctrl_chk.sv
module decim_rate_ctrl_chk #(
   parameter int unsigned CHOP_DIV = 64
) (
   input logic clk,
   input logic rst,
   input logic sync_req,
   input logic data_ready,
   input logic busy,
   input logic chop_tick
);

   localparam int unsigned GW = $clog2(CHOP_DIV) + 1;

   logic [GW-1:0] gap;

   always_ff @(posedge clk) begin
      if (rst || chop_tick) gap <= '0;
      else                  gap <= gap + GW'(1);
   end

   // R12 / R1: reset forces the idle outputs one edge later
   assert_reset_idle_R12: assert property (@(posedge clk)
      rst |=> (busy && !data_ready));

   // R5 / R11: a restart raises busy and drops the strobe
   assert_sync_busy_R11: assert property (@(posedge clk) disable iff (rst)
      sync_req |=> (busy && !data_ready));

   // R5: busy and data-ready never overlap
   assert_ready_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
      data_ready |-> !busy);

   // R5: busy only falls together with the first strobe
   assert_busy_fall_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> data_ready);

   // R4: the strobe lasts a single cycle
   assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
      data_ready |=> !data_ready);

   // R10: ticks are exactly CHOP_DIV clocks apart
   assert_chop_spacing_R10: assert property (@(posedge clk) disable iff (rst)
      chop_tick |-> (gap == GW'(CHOP_DIV - 1)));

endmodule

bind decim_rate_ctrl decim_rate_ctrl_chk #(
   .CHOP_DIV (MOD_CLK_DIV * CHOP_RATIO)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .sync_req   (sync_req),
   .data_ready (data_ready),
   .busy       (busy),
   .chop_tick  (chop_tick)
);

// File: tb/decim_rate_ctrl_bench.sv
module decim_rate_ctrl_bench;

   localparam int CLK_PERIOD  = 10;
   localparam int WATCHDOG    = 195000;
   localparam int SHORT_OVHLS = 40;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_m = 1'b0;
   logic       sync_s = 1'b0;
   logic [2:0] osr_sel = 3'd0;
   logic       low_speed = 1'b0;
   logic       buf_en = 1'b0;
   logic       dr_m, chop_m, busy_m;
   logic       dr_s, chop_s, busy_s;

   int checks = 0;
   int fails  = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   decim_rate_ctrl u_decim_rate_ctrl (
      .clk (clk), .rst (rst), .sync_req (sync_m), .osr_sel (osr_sel),
      .low_speed (low_speed), .buf_en (buf_en),
      .data_ready (dr_m), .chop_tick (chop_m), .busy (busy_m)
   );

   decim_rate_ctrl #(.SETTLE_PERIODS (1), .OVH_LS (SHORT_OVHLS)) u_decim_rate_ctrl_short (
      .clk (clk), .rst (rst), .sync_req (sync_s), .osr_sel (osr_sel),
      .low_speed (low_speed), .buf_en (buf_en),
      .data_ready (dr_s), .chop_tick (chop_s), .busy (busy_s)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected values from the requirements
   function automatic int exp_period(input int sel);
      return 2 * (32 << sel);                                  // R2
   endfunction

   function automatic int exp_latency(input bit short_dut, input int sel,
                                      input bit bufe, input bit spd);
      int ovh;
      ovh = spd ? (short_dut ? SHORT_OVHLS : 16) : 16;          // R9
      return (short_dut ? 1 : 68) * exp_period(sel) + ovh + (bufe ? 8 : 0);  // R3 R8
   endfunction

   // Edge count since the last reset edge, for R10
   always @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   always @(negedge clk) begin
      if (!done) begin
         chk(chop_m == ((edges % 64) == 63), "R10 chop_tick main", chop_m, (edges % 64) == 63);
         chk(chop_s == ((edges % 64) == 63), "R10 chop_tick short", chop_s, (edges % 64) == 63);
      end
   end

   // Issue a restart, then check every cycle until stop_at (or two periods past the first strobe).
   task automatic run_window(input bit use_s, input int sel, input bit bufe, input bit spd,
                             input int stop_at, input string ctx);
      int p, n, last;
      bit d, b, ed, eb;
      p = exp_period(sel);
      n = exp_latency(use_s, sel, bufe, spd);
      @(negedge clk);
      osr_sel   = 3'(sel);
      buf_en    = bufe;
      low_speed = spd;
      if (use_s) sync_s = 1'b1; else sync_m = 1'b1;
      @(negedge clk);
      sync_m = 1'b0;
      sync_s = 1'b0;
      // R7: disturb the configuration right after the restart
      osr_sel   = 3'(sel) ^ 3'b101;
      buf_en    = !bufe;
      low_speed = !spd;
      d = use_s ? dr_s : dr_m;
      b = use_s ? busy_s : busy_m;
      chk(b == 1'b1, {ctx, " R5 busy after restart"}, b, 1);
      chk(d == 1'b0, {ctx, " R11 no strobe after restart"}, d, 0);
      last = (stop_at > 0) ? stop_at : n + 2 * p;
      for (int i = 1; i <= last; i++) begin
         @(negedge clk);
         d  = use_s ? dr_s : dr_m;
         b  = use_s ? busy_s : busy_m;
         ed = (i >= n) && (((i - n) % p) == 0);
         eb = (i < n);
         if (i <= n)
            chk(d == ed, $sformatf("%s R3 R7 strobe at cycle %0d", ctx, i), d, ed);
         else
            chk(d == ed, $sformatf("%s R4 strobe at cycle %0d", ctx, i), d, ed);
         chk(b == eb, $sformatf("%s R5 busy at cycle %0d", ctx, i), b, eb);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(dr_m == 1'b0, "R1 data_ready in reset", dr_m, 0);
      chk(busy_m == 1'b1, "R1 busy in reset", busy_m, 1);
      rst = 1'b0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         chk(dr_m == 1'b0 && dr_s == 1'b0, "R1 no strobe before restart", dr_m | dr_s, 0);
         chk(busy_m == 1'b1 && busy_s == 1'b1, "R1 busy before restart", busy_m & busy_s, 1);
      end

      // Directed cases on the full-latency instance
      run_window(1'b0, 0, 1'b0, 1'b0, 0, "R2 R3 ratio32");
      run_window(1'b0, 1, 1'b1, 1'b0, 0, "R8 R11 buffer ratio64");
      run_window(1'b0, 0, 1'b0, 1'b0, 1500, "R6 before restart");
      run_window(1'b0, 1, 1'b0, 1'b1, 0, "R6 restart in settling");

      // Random configurations
      for (int k = 0; k < 4; k++) begin
         int sel;
         bit bufe, spd;
         sel  = int'($urandom % 3);
         bufe = 1'($urandom);
         spd  = 1'($urandom);
         run_window(1'b0, sel, bufe, spd, 0, "R3 R4 random");
      end

      // R12: reset while strobes are running
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(dr_m == 1'b0, "R12 strobe cleared by reset", dr_m, 0);
      chk(busy_m == 1'b1, "R12 busy set by reset", busy_m, 1);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         chk(dr_m == 1'b0, "R1 R12 no strobe after reset", dr_m, 0);
         chk(busy_m == 1'b1, "R1 R12 busy after reset", busy_m, 1);
      end

      // All eight ratio codes and both overheads on the short instance
      for (int sel = 0; sel < 8; sel++) begin
         run_window(1'b1, sel, 1'(sel), 1'(sel >> 1), 0, "R2 R9 short");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule